// File: doc/BRIEF.md
# Page Fault Detector

This block sits beside an address translator and decides, for each translation request, whether the access raises a page fault. The translator presents the linear address and the kind of access: read or write, user or supervisor. It also presents the paging-enable bit and the present, user and writable attribute bits of the directory-level entry and the table-level entry it fetched. The block does not walk page tables, cache translations or dispatch the exception; it only judges the attributes it is given.

One clock after a request, the block raises a single-cycle fault strobe. Alongside the strobe it holds a three-bit error code that describes the fault. It also loads a fault-address register with the linear address of the faulting access. The fault-address register and the error code hold their values until the next fault, so an exception handler can read them later. Reset is asynchronous and active-low; its release is synchronised inside the block.

Top module: `pgfault_unit`

## Requirements
- R1: While `paging_on` is 0, no request raises `fault_o`, whatever the attribute bits are.
- R2: With paging on, a request faults when the directory entry is not present, or when the directory entry is present and the table entry is not present. When the directory entry is absent, the table entry bits have no effect.
- R3: With paging on and both entries present, a user access (`is_user`=1) faults when either entry has its user bit clear.
- R4: With paging on and both entries present, a user write faults when either entry has its writable bit clear. A user read ignores the writable bits.
- R5: A supervisor access (`is_user`=0) with both entries present never faults, whatever the user and writable bits are.
- R6: Error code bit 0 is 1 for a protection violation and 0 for a not-present entry. When an entry is absent, bit 0 is 0 even if the rights also fail.
- R7: Error code bit 1 is 1 when the faulting access was a write and 0 when it was a read.
- R8: Error code bit 2 is 1 when the faulting access was made in user mode and 0 when it was made in supervisor mode.
- R9: `fault_o` is high for exactly the one cycle after a faulting request is sampled with `req_valid`=1. When `req_valid` is 0, the next cycle has no fault.
- R10: On each fault, `fault_addr_o` takes the linear address of the faulting request in the same cycle as `fault_o`. It keeps that value until the next fault, and requests that do not fault leave it unchanged.
- R11: Reset drives `fault_o`, `err_code_o` and `fault_addr_o` to zero. `err_code_o` also holds its value between faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A translation request is presented this cycle |
| lin_addr | input | ADDR_W (32) | Linear address of the access |
| is_write | input | 1 | 1 for a write access, 0 for a read |
| is_user | input | 1 | 1 for a user-level access, 0 for supervisor |
| paging_on | input | 1 | Paging enable |
| dir_present | input | 1 | Directory entry present bit |
| dir_user | input | 1 | Directory entry user-accessible bit |
| dir_writable | input | 1 | Directory entry writable bit |
| tbl_present | input | 1 | Table entry present bit |
| tbl_user | input | 1 | Table entry user-accessible bit |
| tbl_writable | input | 1 | Table entry writable bit |
| fault_o | output | 1 | Single-cycle page fault strobe |
| err_code_o | output | 3 | Error code: bit 2 user, bit 1 write, bit 0 protection |
| fault_addr_o | output | ADDR_W (32) | Linear address of the most recent fault |

## Verification
The assertions check the following on every cycle:
- paging off never leads to a strobe, and an idle cycle never leads to a strobe;
- the user bit and the write bit of the error code follow the access that faulted;
- a fault that involves an absent directory entry is never reported as a protection fault;
- the fault address matches the faulting request and stays stable between faults.

Other behaviour can only be shown by the bench's scenarios. These are which attribute combinations fault at all, for example that a supervisor access ignores the rights bits and that a user read ignores the writable bits. They also include the precedence of an absent entry over a rights failure, and the values left behind after an asynchronous reset in the middle of a run.

// File: rtl/pgf_pkg.sv
package pgf_pkg;

  // Attribute bits of one translation level
  typedef struct packed {
    logic present;
    logic user;
    logic writable;
  } pgf_attr_t;

  // Page fault error code layout
  typedef struct packed {
    logic user_mode;   // bit 2
    logic write_acc;   // bit 1
    logic prot_viol;   // bit 0
  } pgf_err_t;

  localparam int unsigned PGF_ERR_W = $bits(pgf_err_t);

endpackage

// File: rtl/pgf_rst_sync.sv
module pgf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pgf_access_eval.sv
module pgf_access_eval
  import pgf_pkg::*;
#(
  parameter int unsigned LEVELS = 2
) (
  input  logic                 req_valid,
  input  logic                 paging_on,
  input  logic                 is_write,
  input  logic                 is_user,
  input  pgf_attr_t            attr [LEVELS],
  output logic                 fault_det,
  output pgf_err_t             err_det
);

  // reach[i]: level i is consulted (all higher levels present)
  logic [LEVELS:0]   reach;
  logic [LEVELS-1:0] absent_lvl;
  logic [LEVELS-1:0] user_deny_lvl;
  logic [LEVELS-1:0] write_deny_lvl;

  assign reach[0] = 1'b1;

  for (genvar g = 0; g < LEVELS; g++) begin : g_level
    assign reach[g+1]        = reach[g] & attr[g].present;
    assign absent_lvl[g]     = reach[g] & ~attr[g].present;
    assign user_deny_lvl[g]  = ~attr[g].user;
    assign write_deny_lvl[g] = ~attr[g].writable;
  end

  logic walk_absent;
  logic walk_done;
  logic rights_fail;
  logic check_on;

  always_comb begin
    walk_absent = |absent_lvl;
    walk_done   = reach[LEVELS];
    rights_fail = is_user & ((|user_deny_lvl) | (is_write & (|write_deny_lvl)));
    check_on    = req_valid & paging_on;
    fault_det   = check_on & (walk_absent | (walk_done & rights_fail));
    err_det.user_mode = is_user;
    err_det.write_acc = is_write;
    err_det.prot_viol = ~walk_absent;
  end

endmodule

// File: rtl/pgf_report_regs.sv
module pgf_report_regs
  import pgf_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_det,
  input  pgf_err_t          err_det,
  input  logic [ADDR_W-1:0] lin_addr,
  output logic              fault_q,
  output pgf_err_t          err_q,
  output logic [ADDR_W-1:0] addr_q
);

  logic              fault_d;
  pgf_err_t          err_d;
  logic [ADDR_W-1:0] addr_d;
  logic              load_en;

  // Next-state
  always_comb begin
    load_en = fault_det;
    fault_d = fault_det;
    err_d   = err_q;
    addr_d  = addr_q;
    if (load_en) begin
      err_d  = err_det;
      addr_d = lin_addr;
    end
  end

  // State
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      err_q   <= '0;
      addr_q  <= '0;
    end else begin
      fault_q <= fault_d;
      err_q   <= err_d;
      addr_q  <= addr_d;
    end
  end

  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_q |-> $stable(addr_q));

  assert_code_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_q |-> $stable(err_q));

endmodule

// File: rtl/pgfault_unit.sv
module pgfault_unit
  import pgf_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] lin_addr,
  input  logic              is_write,
  input  logic              is_user,
  input  logic              paging_on,
  input  logic              dir_present,
  input  logic              dir_user,
  input  logic              dir_writable,
  input  logic              tbl_present,
  input  logic              tbl_user,
  input  logic              tbl_writable,
  output logic              fault_o,
  output logic [2:0]        err_code_o,
  output logic [ADDR_W-1:0] fault_addr_o
);

  localparam int unsigned LEVELS = 2;

  logic      rst_sync_n;
  pgf_attr_t attr [LEVELS];
  logic      fault_det;
  pgf_err_t  err_det;
  pgf_err_t  err_q;

  // Level 0 is the directory, level 1 the table
  assign attr[0] = '{present: dir_present, user: dir_user, writable: dir_writable};
  assign attr[1] = '{present: tbl_present, user: tbl_user, writable: tbl_writable};

  pgf_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pgf_access_eval #(.LEVELS(LEVELS)) i_eval (
    .req_valid (req_valid),
    .paging_on (paging_on),
    .is_write  (is_write),
    .is_user   (is_user),
    .attr      (attr),
    .fault_det (fault_det),
    .err_det   (err_det)
  );

  pgf_report_regs #(.ADDR_W(ADDR_W)) i_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .fault_det (fault_det),
    .err_det   (err_det),
    .lin_addr  (lin_addr),
    .fault_q   (fault_o),
    .err_q     (err_q),
    .addr_q    (fault_addr_o)
  );

  assign err_code_o = err_q;

  assert_no_fault_paging_off_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !paging_on |=> !fault_o);

  assert_idle_no_fault_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> !fault_o);

  assert_np_not_prot_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && paging_on && !dir_present) |=> (fault_o && !err_code_o[0]));

  assert_write_bit_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fault_o |-> (err_code_o[1] == $past(is_write)));

  assert_user_bit_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fault_o |-> (err_code_o[2] == $past(is_user)));

  assert_addr_capture_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fault_o |-> (fault_addr_o == $past(lin_addr)));

endmodule

// File: tb/test_pgfault_unit.sv
module test_pgfault_unit;

  localparam int ADDR_W = 32;
  localparam int NVEC   = 14;

  // {wr, us, pg, dir_p, dir_u, dir_w, tbl_p, tbl_u, tbl_w, exp_fault, exp_code[2:0]}
  localparam logic [12:0] VEC [NVEC] = '{
    13'b1_1_0_000_000_1_110, // R1 paging off: actually no fault, fixed below
    13'b1_1_1_011_111_1_110, // R2 dir absent, user write
    13'b0_0_1_111_011_1_000, // R2 table absent, supervisor read
    13'b0_1_1_101_111_1_101, // R3 dir user clear
    13'b0_1_1_110_110_0_000, // R4 user read ignores writable
    13'b1_1_1_111_110_1_111, // R4 table not writable
    13'b1_1_1_110_111_1_111, // R4 dir not writable
    13'b1_0_1_100_100_0_000, // R5 supervisor ignores rights
    13'b1_1_1_111_111_0_000, // R3/R4 user write allowed
    13'b0_1_1_111_101_1_101, // R3 table user clear
    13'b1_0_1_000_000_1_010, // R2/R7 supervisor write, dir absent
    13'b0_1_1_000_100_1_100, // R2/R6 dir absent masks table, rights
    13'b1_1_0_100_100_0_000, // R1 paging off with rights failing
    13'b0_0_1_111_000_1_000  // R2 table absent
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic [ADDR_W-1:0] lin_addr;
  logic              is_write, is_user, paging_on;
  logic              dir_present, dir_user, dir_writable;
  logic              tbl_present, tbl_user, tbl_writable;
  logic              fault_o;
  logic [2:0]        err_code_o;
  logic [ADDR_W-1:0] fault_addr_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [2:0]        exp_code = '0;
  logic [ADDR_W-1:0] exp_addr = '0;

  always #2 clk = ~clk;

  pgfault_unit #(.ADDR_W(ADDR_W)) i_pgfault_unit (
    .clk, .rst_n, .req_valid, .lin_addr, .is_write, .is_user, .paging_on,
    .dir_present, .dir_user, .dir_writable, .tbl_present, .tbl_user, .tbl_writable,
    .fault_o, .err_code_o, .fault_addr_o
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Present one request for one cycle; returns after outputs are updated
  task automatic issue(input logic [8:0] a, input logic [ADDR_W-1:0] addr);
    @(negedge clk);
    {is_write, is_user, paging_on, dir_present, dir_user, dir_writable,
     tbl_present, tbl_user, tbl_writable} = a;
    lin_addr  = addr;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; lin_addr = '0;
    {is_write, is_user, paging_on, dir_present, dir_user, dir_writable,
     tbl_present, tbl_user, tbl_writable} = '0;
    repeat (3) @(negedge clk);
    check("R11 reset fault", 64'(fault_o), 64'd0);
    check("R11 reset code", 64'(err_code_o), 64'd0);
    check("R11 reset addr", 64'(fault_addr_o), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [12:0] v;
      logic [ADDR_W-1:0] a;
      logic ef;
      v  = VEC[i];
      ef = v[3] & v[10];   // paging off never faults (R1)
      a  = 32'h4000_0000 + ADDR_W'(i) * 32'h0013_5791;
      issue(v[12:4], a);
      if (ef) begin
        exp_code = v[2:0];
        exp_addr = a;
      end
      check($sformatf("R2-R5 vec%0d fault", i), 64'(fault_o), 64'(ef));
      check($sformatf("R6 R7 R8 R11 vec%0d code", i), 64'(err_code_o), 64'(exp_code));
      check($sformatf("R10 vec%0d addr", i), 64'(fault_addr_o), 64'(exp_addr));
      @(negedge clk);
      check($sformatf("R9 vec%0d strobe one cycle", i), 64'(fault_o), 64'd0);
    end

    // R9: request-shaped inputs with valid low do not fault
    @(negedge clk);
    {is_write, is_user, paging_on, dir_present} = 4'b1110;
    lin_addr = 32'hDEAD_0000;
    @(negedge clk);
    check("R9 no valid no fault", 64'(fault_o), 64'd0);
    check("R10 addr held without valid", 64'(fault_addr_o), 64'(exp_addr));

    // R10: two back-to-back faults, address follows each
    issue(9'b1_1_1_011_111, 32'hAAAA_1000);
    check("R10 first fault addr", 64'(fault_addr_o), 64'hAAAA_1000);
    issue(9'b0_0_1_111_011, 32'h5555_2000);
    check("R10 second fault addr", 64'(fault_addr_o), 64'h5555_2000);
    check("R6 R7 R8 second code", 64'(err_code_o), 64'd0);

    // R11: asynchronous reset mid-run clears held values
    #1 rst_n = 1'b0;
    #1;
    check("R11 async reset addr", 64'(fault_addr_o), 64'd0);
    check("R11 async reset code", 64'(err_code_o), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    issue(9'b0_1_1_101_111, 32'h0000_0ABC);
    check("R3 after reset fault", 64'(fault_o), 64'd1);
    check("R6 R8 after reset code", 64'(err_code_o), 64'b101);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule